// File: doc/BRIEF.md
# DMA Coherence Transaction Tracker

This block runs one DMA read or DMA write to a coherent line from start to finish. When a request is accepted, the block allocates a single tracking entry. It then broadcasts one snoop to every last-level cache. A DMA read sends a shared-read snoop and a DMA write sends an exclusive-read snoop. Where the line's current directory state calls for it, the block also fetches the line from memory. It counts one response from each cache and remembers whether any cache still holds a shared copy. If a cache returns data, that data takes priority over memory data.

When every response has arrived, and the memory data too where it was fetched, the block emits a completion trigger for one cycle. The trigger carries a flag that says whether sharers remain. For a read, the block then returns the whole line to the DMA requestor and reports the new stable directory state. For a write, the block overlays the DMA bytes onto the current line, using the byte offset and the length. It writes the merged line to memory. When memory acknowledges the write, the block acknowledges the requestor and reports the line as Exclusive.

The controller has eight states:
- `ST_IDLE`: accepting. It moves to `ST_ISSUE` on a request.
- `ST_ISSUE`: drives the snoop and, when needed, the fetch. It moves to `ST_COLLECT`.
- `ST_COLLECT`: counts responses. It moves to `ST_COMPLETE` when the count is zero and no memory data is outstanding.
- `ST_COMPLETE`: drives the trigger. It moves to `ST_RD_REPLY` for a read or `ST_WR_SEND` for a write.
- `ST_RD_REPLY`: returns the line. It moves to `ST_IDLE`.
- `ST_WR_SEND`: writes the merged line. It moves to `ST_WR_WAIT`.
- `ST_WR_WAIT`: waits for the memory acknowledge. It moves to `ST_WR_REPLY` when the acknowledge arrives.
- `ST_WR_REPLY`: acknowledges the requestor. It moves to `ST_IDLE`.

Top module: `dma_coh_tracker`

## Requirements
- R1: After reset the block is idle. `req_accept` is 1, and `snoop_valid`, `done_valid`, `dma_out_valid`, `mem_wr_valid` and `stray_resp` are all 0.
- R2: `req_accept` is 1 only in the idle state. An accepted request produces a one-cycle snoop in the next cycle. The snoop has `snoop_excl` = `req_write` and `snoop_addr` = the request address with its low 6 bits cleared. A request presented while busy is not taken: no new snoop is issued, and the reply carries the original request's id.
- R3: `mem_rd_valid` is asserted together with the snoop for every write, and for a read whose `req_line_state` is Owner (1) or Exclusive (2). It is not asserted for a read whose `req_line_state` is Not-Owner (0).
- R4: `rsp_kind` has four codes: 0 plain ack, 1 shared ack, 2 shared data, 3 exclusive data. Each response lowers the pending count by exactly one from its start value of NUM_CACHES. Completion waits until the count is zero and any fetched memory data has arrived.
- R5: Completion raises `done_valid` for exactly one cycle. `done_shared` is 1 if any response had code 1 or code 2, and 0 otherwise.
- R6: A line delivered by a data response (code 2 or 3) is kept in preference to memory data, whichever of the two arrives first. Memory data is stored only while no cache data has been received.
- R7: In the cycle after the trigger, a read returns `dma_out_line` with `dma_out_ack` = 0 and the request's id. In the same cycle it reports `dir_state` Owner (1) if sharers remain and Exclusive (2) if none remain.
- R8: In the cycle after the trigger, a write drives `mem_wr_valid` with the line address. `mem_wr_line` equals the stored line with bytes offset to offset+len-1 replaced by the DMA bytes. The offset is the low 6 bits of the address, and byte b sits at bits [8b+7:8b]. The replaced range stops at byte 63, and a length of 0 changes nothing.
- R9: A write reply (`dma_out_ack` = 1, `dir_state` Exclusive) appears only in the cycle after `mem_wr_done` is sampled while the write is waiting.
- R10: A response that arrives while the pending count is zero raises `stray_resp` in that cycle. The response changes neither the count, the line nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | DMA request present |
| req_write | input | 1 | 1 = DMA write, 0 = DMA read |
| req_addr | input | ADDR_W | Physical byte address |
| req_len | input | clog2(LINE_BYTES+1) | Write length in bytes |
| req_line_state | input | 2 | Current stable directory state of the line |
| req_data | input | LINE_BYTES*8 | DMA write bytes, positioned by byte lane |
| req_id | input | ID_W | Requestor tag |
| req_accept | output | 1 | Tracker free; request taken this cycle |
| snoop_valid | output | 1 | Broadcast snoop to all caches |
| snoop_excl | output | 1 | 1 = exclusive-read snoop, 0 = shared-read snoop |
| snoop_addr | output | ADDR_W | Line address of the snoop |
| rsp_valid | input | 1 | Cache response present |
| rsp_kind | input | 2 | Response code |
| rsp_line | input | LINE_BYTES*8 | Line carried by a data response |
| mem_rd_valid | output | 1 | Memory fetch request |
| mem_wr_valid | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Line address for memory |
| mem_wr_line | output | LINE_BYTES*8 | Merged line to write |
| mem_rd_done | input | 1 | Fetched data present |
| mem_rd_line | input | LINE_BYTES*8 | Fetched line |
| mem_wr_done | input | 1 | Memory write acknowledge |
| done_valid | output | 1 | Completion trigger |
| done_shared | output | 1 | Sharers remain |
| dma_out_valid | output | 1 | Reply to DMA requestor |
| dma_out_ack | output | 1 | 1 = write ack, 0 = read data |
| dma_out_line | output | LINE_BYTES*8 | Full line for a read |
| dma_out_id | output | ID_W | Tag of the request being answered |
| dir_valid | output | 1 | Stable-state update present |
| dir_state | output | 2 | New stable state: 1 Owner, 2 Exclusive |
| stray_resp | output | 1 | Response received with nothing pending |

## Verification
The main function is exercised with reads from each of the three line states, which separates the cases with and without a memory fetch. It is also exercised with response mixes of plain acks, shared acks, shared data and exclusive data, which separates the sharer flag from the dirty flag. Memory data is sent both before and after the cache data, which shows whether dirty cache data survives a late memory fill. Writes are tried with a mid-line window, a window that runs past the end of the line, a full line and a zero length, which exposes errors in the mask bounds. A request presented while busy, and a response beyond the expected count, show that the tracker neither restarts nor miscounts.

// File: rtl/dct_pkg.sv
package dct_pkg;

    typedef enum logic [1:0] {
        LS_NOT_OWNER = 2'd0,
        LS_OWNER     = 2'd1,
        LS_EXCLUSIVE = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        RK_ACK         = 2'd0,
        RK_SHARED_ACK  = 2'd1,
        RK_SHARED_DATA = 2'd2,
        RK_EXCL_DATA   = 2'd3
    } rsp_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_COLLECT,
        ST_COMPLETE,
        ST_RD_REPLY,
        ST_WR_SEND,
        ST_WR_WAIT,
        ST_WR_REPLY
    } trk_state_e;

endpackage

// File: rtl/dct_ack_counter.sv
module dct_ack_counter
    import dct_pkg::*;
#(
    parameter int NUM_CACHES = 4,
    parameter int CNT_W      = $clog2(NUM_CACHES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       rsp_valid,
    input  logic [1:0] rsp_kind,
    output logic       pend_zero,
    output logic       sharer,
    output logic       dirty,
    output logic       stray,
    output logic       take
);

    logic [CNT_W-1:0] pend;

    assign pend_zero = (pend == '0);
    assign stray     = rsp_valid && pend_zero;
    assign take      = rsp_valid && !pend_zero;

    // Each response counts as exactly one, whatever it carries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= '0;
            sharer <= 1'b0;
            dirty  <= 1'b0;
        end else if (load) begin
            pend   <= CNT_W'(NUM_CACHES);
            sharer <= 1'b0;
            dirty  <= 1'b0;
        end else if (take) begin
            pend <= pend - 1'b1;
            if (rsp_kind == RK_SHARED_ACK || rsp_kind == RK_SHARED_DATA)
                sharer <= 1'b1;
            if (rsp_kind == RK_SHARED_DATA || rsp_kind == RK_EXCL_DATA)
                dirty <= 1'b1;
        end
    end

endmodule

// File: rtl/dct_line_store.sv
module dct_line_store #(
    parameter int LINE_W = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              cache_we,
    input  logic [LINE_W-1:0] cache_line,
    input  logic              mem_we,
    input  logic [LINE_W-1:0] mem_line,
    output logic [LINE_W-1:0] line
);

    // Cache data has priority over a memory fill in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)        line <= '0;
        else if (clear)    line <= '0;
        else if (cache_we) line <= cache_line;
        else if (mem_we)   line <= mem_line;
    end

endmodule

// File: rtl/dct_byte_merge.sv
module dct_byte_merge #(
    parameter int LINE_BYTES = 64,
    parameter int OFF_W      = $clog2(LINE_BYTES),
    parameter int LEN_W      = $clog2(LINE_BYTES + 1)
) (
    input  logic [LINE_BYTES*8-1:0] base,
    input  logic [LINE_BYTES*8-1:0] wdata,
    input  logic [OFF_W-1:0]        offset,
    input  logic [LEN_W-1:0]        len,
    output logic [LINE_BYTES*8-1:0] merged
);

    localparam int EW = LEN_W + 1;

    logic [EW-1:0] first_b;
    logic [EW-1:0] end_b;

    assign first_b = EW'(offset);
    assign end_b   = first_b + EW'(len);

    // Byte lanes past the end of the line simply do not exist
    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
        logic sel;
        assign sel = (EW'(b) >= first_b) && (EW'(b) < end_b);
        assign merged[b*8 +: 8] = sel ? wdata[b*8 +: 8] : base[b*8 +: 8];
    end

endmodule

// File: rtl/dma_coh_tracker.sv
module dma_coh_tracker
    import dct_pkg::*;
#(
    parameter int NUM_CACHES = 4,
    parameter int LINE_BYTES = 64,
    parameter int ADDR_W     = 32,
    parameter int ID_W       = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [$clog2(LINE_BYTES+1)-1:0] req_len,
    input  logic [1:0]                     req_line_state,
    input  logic [LINE_BYTES*8-1:0]        req_data,
    input  logic [ID_W-1:0]                req_id,
    output logic                           req_accept,
    output logic                           snoop_valid,
    output logic                           snoop_excl,
    output logic [ADDR_W-1:0]              snoop_addr,
    input  logic                           rsp_valid,
    input  logic [1:0]                     rsp_kind,
    input  logic [LINE_BYTES*8-1:0]        rsp_line,
    output logic                           mem_rd_valid,
    output logic                           mem_wr_valid,
    output logic [ADDR_W-1:0]              mem_addr,
    output logic [LINE_BYTES*8-1:0]        mem_wr_line,
    input  logic                           mem_rd_done,
    input  logic [LINE_BYTES*8-1:0]        mem_rd_line,
    input  logic                           mem_wr_done,
    output logic                           done_valid,
    output logic                           done_shared,
    output logic                           dma_out_valid,
    output logic                           dma_out_ack,
    output logic [LINE_BYTES*8-1:0]        dma_out_line,
    output logic [ID_W-1:0]                dma_out_id,
    output logic                           dir_valid,
    output logic [1:0]                     dir_state,
    output logic                           stray_resp
);

    localparam int LINE_W = LINE_BYTES * 8;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int LEN_W  = $clog2(LINE_BYTES + 1);

    trk_state_e state, state_nx;

    logic              ctx_write;
    logic              ctx_fetch;
    logic [ADDR_W-1:0] ctx_addr;
    logic [LEN_W-1:0]  ctx_len;
    logic [ID_W-1:0]   ctx_id;
    logic [LINE_W-1:0] ctx_data;
    logic              mem_wait;

    logic              accept_now;
    logic              need_fetch;
    logic              pend_zero, sharer, dirty, take;
    logic              is_data_rsp;
    logic [LINE_W-1:0] line_q;
    logic [ADDR_W-1:0] line_addr;

    assign accept_now  = req_valid && (state == ST_IDLE);
    assign need_fetch  = req_write || (req_line_state != LS_NOT_OWNER);
    assign is_data_rsp = (rsp_kind == RK_SHARED_DATA) || (rsp_kind == RK_EXCL_DATA);
    assign line_addr   = {ctx_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    dct_ack_counter #(
        .NUM_CACHES(NUM_CACHES)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept_now),
        .rsp_valid (rsp_valid),
        .rsp_kind  (rsp_kind),
        .pend_zero (pend_zero),
        .sharer    (sharer),
        .dirty     (dirty),
        .stray     (stray_resp),
        .take      (take)
    );

    dct_line_store #(
        .LINE_W(LINE_W)
    ) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept_now),
        .cache_we   (take && is_data_rsp),
        .cache_line (rsp_line),
        .mem_we     (mem_rd_done && mem_wait && !dirty),
        .mem_line   (mem_rd_line),
        .line       (line_q)
    );

    dct_byte_merge #(
        .LINE_BYTES(LINE_BYTES)
    ) u_merge (
        .base   (line_q),
        .wdata  (ctx_data),
        .offset (ctx_addr[OFF_W-1:0]),
        .len    (ctx_len),
        .merged (mem_wr_line)
    );

    // Transaction context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_write <= 1'b0;
            ctx_fetch <= 1'b0;
            ctx_addr  <= '0;
            ctx_len   <= '0;
            ctx_id    <= '0;
            ctx_data  <= '0;
            mem_wait  <= 1'b0;
        end else if (accept_now) begin
            ctx_write <= req_write;
            ctx_fetch <= need_fetch;
            ctx_addr  <= req_addr;
            ctx_len   <= req_len;
            ctx_id    <= req_id;
            ctx_data  <= req_data;
            mem_wait  <= need_fetch;
        end else if (mem_rd_done) begin
            mem_wait  <= 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (req_valid) state_nx = ST_ISSUE;
            ST_ISSUE:    state_nx = ST_COLLECT;
            ST_COLLECT:  if (pend_zero && !mem_wait) state_nx = ST_COMPLETE;
            ST_COMPLETE: state_nx = ctx_write ? ST_WR_SEND : ST_RD_REPLY;
            ST_RD_REPLY: state_nx = ST_IDLE;
            ST_WR_SEND:  state_nx = ST_WR_WAIT;
            ST_WR_WAIT:  if (mem_wr_done) state_nx = ST_WR_REPLY;
            ST_WR_REPLY: state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    assign snoop_addr   = line_addr;
    assign mem_addr     = line_addr;
    assign dma_out_line = line_q;
    assign dma_out_id   = ctx_id;

    // Outputs
    always_comb begin
        req_accept    = 1'b0;
        snoop_valid   = 1'b0;
        snoop_excl    = 1'b0;
        mem_rd_valid  = 1'b0;
        mem_wr_valid  = 1'b0;
        done_valid    = 1'b0;
        done_shared   = 1'b0;
        dma_out_valid = 1'b0;
        dma_out_ack   = 1'b0;
        dir_valid     = 1'b0;
        dir_state     = LS_NOT_OWNER;
        unique case (state)
            ST_IDLE:     req_accept = 1'b1;
            ST_ISSUE: begin
                snoop_valid  = 1'b1;
                snoop_excl   = ctx_write;
                mem_rd_valid = ctx_fetch;
            end
            ST_COLLECT:  ;
            ST_COMPLETE: begin
                done_valid  = 1'b1;
                done_shared = sharer;
            end
            ST_RD_REPLY: begin
                dma_out_valid = 1'b1;
                dir_valid     = 1'b1;
                dir_state     = sharer ? LS_OWNER : LS_EXCLUSIVE;
            end
            ST_WR_SEND:  mem_wr_valid = 1'b1;
            ST_WR_WAIT:  ;
            ST_WR_REPLY: begin
                dma_out_valid = 1'b1;
                dma_out_ack   = 1'b1;
                dir_valid     = 1'b1;
                dir_state     = LS_EXCLUSIVE;
            end
            default:     ;
        endcase
    end

endmodule

// File: rtl/dct_checker.sv
module dct_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_accept,
    input logic snoop_valid,
    input logic mem_rd_valid,
    input logic mem_wr_valid,
    input logic mem_wr_done,
    input logic rsp_valid,
    input logic done_valid,
    input logic dma_out_valid,
    input logic dma_out_ack,
    input logic dir_valid,
    input logic stray_resp
);

    a_r1_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({snoop_valid, done_valid, dma_out_valid, mem_wr_valid}));

    a_r2_snoop_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_accept) |=> snoop_valid);

    a_r2_busy_during_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_valid |-> !req_accept);

    a_r3_fetch_with_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> snoop_valid);

    a_r5_trigger_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    a_r7_read_after_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_out_valid && !dma_out_ack) |-> $past(done_valid));

    a_r7_dir_with_reply: assert property (@(posedge clk) disable iff (!rst_n)
        dir_valid |-> dma_out_valid);

    a_r9_ack_after_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_out_valid && dma_out_ack) |-> $past(mem_wr_done));

    a_r10_stray_needs_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        stray_resp |-> rsp_valid);

endmodule

bind dma_coh_tracker dct_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_accept    (req_accept),
    .snoop_valid   (snoop_valid),
    .mem_rd_valid  (mem_rd_valid),
    .mem_wr_valid  (mem_wr_valid),
    .mem_wr_done   (mem_wr_done),
    .rsp_valid     (rsp_valid),
    .done_valid    (done_valid),
    .dma_out_valid (dma_out_valid),
    .dma_out_ack   (dma_out_ack),
    .dir_valid     (dir_valid),
    .stray_resp    (stray_resp)
);

// File: tb/dma_coh_tracker_tb.sv
module dma_coh_tracker_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int LB = 64;
    localparam int LW = LB * 8;

    // {write, line_state, offset, len, kinds c3..c0, mem_first, pad}
    localparam int NV = 8;
    localparam logic [25:0] VEC [0:NV-1] = '{
        {1'b0, 2'd2, 6'd0,  7'd0,  8'b00_00_00_00, 1'b1, 1'b0},
        {1'b0, 2'd1, 6'd0,  7'd0,  8'b00_00_01_00, 1'b1, 1'b0},
        {1'b0, 2'd0, 6'd0,  7'd0,  8'b00_00_00_11, 1'b0, 1'b0},
        {1'b0, 2'd2, 6'd0,  7'd0,  8'b00_01_10_00, 1'b0, 1'b0},
        {1'b1, 2'd2, 6'd8,  7'd16, 8'b00_00_00_00, 1'b1, 1'b0},
        {1'b1, 2'd0, 6'd60, 7'd10, 8'b00_11_00_00, 1'b0, 1'b0},
        {1'b1, 2'd1, 6'd0,  7'd64, 8'b00_00_00_00, 1'b1, 1'b0},
        {1'b1, 2'd2, 6'd5,  7'd0,  8'b01_00_00_00, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [6:0] req_len = '0;
    logic [1:0] req_line_state = '0;
    logic [LW-1:0] req_data = '0;
    logic [3:0] req_id = '0;
    logic req_accept, snoop_valid, snoop_excl;
    logic [31:0] snoop_addr, mem_addr;
    logic rsp_valid = 1'b0;
    logic [1:0] rsp_kind = '0;
    logic [LW-1:0] rsp_line = '0;
    logic mem_rd_valid, mem_wr_valid;
    logic [LW-1:0] mem_wr_line, dma_out_line;
    logic mem_rd_done = 1'b0, mem_wr_done = 1'b0;
    logic [LW-1:0] mem_rd_line = '0;
    logic done_valid, done_shared, dma_out_valid, dma_out_ack, dir_valid, stray_resp;
    logic [3:0] dma_out_id;
    logic [1:0] dir_state;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_coh_tracker #(.NUM_CACHES(NC), .LINE_BYTES(LB), .ADDR_W(32), .ID_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
        .req_line_state(req_line_state), .req_data(req_data), .req_id(req_id),
        .req_accept(req_accept), .snoop_valid(snoop_valid), .snoop_excl(snoop_excl),
        .snoop_addr(snoop_addr), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_line(rsp_line),
        .mem_rd_valid(mem_rd_valid), .mem_wr_valid(mem_wr_valid), .mem_addr(mem_addr),
        .mem_wr_line(mem_wr_line), .mem_rd_done(mem_rd_done), .mem_rd_line(mem_rd_line),
        .mem_wr_done(mem_wr_done), .done_valid(done_valid), .done_shared(done_shared),
        .dma_out_valid(dma_out_valid), .dma_out_ack(dma_out_ack), .dma_out_line(dma_out_line),
        .dma_out_id(dma_out_id), .dir_valid(dir_valid), .dir_state(dir_state),
        .stray_resp(stray_resp)
    );

    task automatic chk(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] rep(input logic [31:0] w);
        return {16{w}};
    endfunction
    function automatic logic [LW-1:0] mline(input int i);
        return rep(32'hA5A50000 | i);
    endfunction
    function automatic logic [LW-1:0] cline(input int i, input int k);
        return rep(32'hC0DE0000 | (i << 4) | k);
    endfunction
    function automatic logic [LW-1:0] dline(input int i);
        return rep(32'h5A5A5A00 | i);
    endfunction
    function automatic logic [LW-1:0] merge_exp(input logic [LW-1:0] base, input logic [LW-1:0] d,
                                                 input int off, input int len);
        logic [LW-1:0] r = base;
        for (int b = 0; b < LB; b++)
            if (b >= off && b < off + len) r[b*8 +: 8] = d[b*8 +: 8];
        return r;
    endfunction

    task automatic send_mem(input int idx);
        mem_rd_done = 1'b1; mem_rd_line = mline(idx);
        @(negedge clk);
        mem_rd_done = 1'b0;
    endtask

    task automatic wait_trigger(input string req);
        for (int n = 0; n < 10 && !done_valid; n++) @(negedge clk);
        chk(done_valid, req, LW'(done_valid), LW'(1));
    endtask

    task automatic run_vec(input int idx, input logic [25:0] v);
        bit wr = v[25];
        logic [1:0] ls = v[24:23];
        int off = int'(v[22:17]);
        int len = int'(v[16:10]);
        bit mf = v[1];
        bit fetch = wr || (ls != 2'd0);
        bit exp_sh = 1'b0, exp_dirty = 1'b0;
        logic [LW-1:0] base;
        logic [31:0] addr = 32'h0001_0000 + 32'(idx * 64 + off);
        logic [31:0] laddr = addr & ~32'h3F;
        base = fetch ? mline(idx) : '0;
        for (int k = 0; k < NC; k++) begin
            logic [1:0] kd = v[2 + 2*k +: 2];
            if (kd == 2'd1 || kd == 2'd2) exp_sh = 1'b1;
            if (kd == 2'd2 || kd == 2'd3) begin exp_dirty = 1'b1; base = cline(idx, k); end
        end

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_len = 7'(len);
        req_line_state = ls; req_data = dline(idx); req_id = 4'(idx);
        #1 chk(req_accept, "R2 accept when idle", LW'(req_accept), LW'(1));
        @(negedge clk);
        req_valid = 1'b0;
        chk(snoop_valid && snoop_excl == wr && snoop_addr == laddr, "R2 snoop kind/addr",
            LW'({snoop_valid, snoop_excl, snoop_addr}), LW'({1'b1, wr, laddr}));
        chk(mem_rd_valid == fetch, "R3 fetch decision", LW'(mem_rd_valid), LW'(fetch));
        if (mf && fetch) send_mem(idx);
        for (int k = 0; k < NC; k++) begin
            rsp_valid = 1'b1; rsp_kind = v[2 + 2*k +: 2]; rsp_line = cline(idx, k);
            @(negedge clk);
        end
        rsp_valid = 1'b0;
        if (!mf && fetch) begin
            @(negedge clk);
            chk(!done_valid, "R4 completion waits for memory", LW'(done_valid), LW'(0));
            send_mem(idx);
        end
        wait_trigger("R5 trigger raised");
        chk(done_shared == exp_sh, "R5 sharer flag", LW'(done_shared), LW'(exp_sh));
        @(negedge clk);
        if (!wr) begin
            chk(dma_out_valid && !dma_out_ack && dma_out_id == 4'(idx), "R7 read reply",
                LW'({dma_out_valid, dma_out_ack, dma_out_id}), LW'({1'b1, 1'b0, 4'(idx)}));
            chk(dma_out_line == base, exp_dirty ? "R6 dirty data kept" : "R7 read line",
                dma_out_line, base);
            chk(dir_valid && dir_state == (exp_sh ? 2'd1 : 2'd2), "R7 stable state",
                LW'(dir_state), LW'(exp_sh ? 2'd1 : 2'd2));
        end else begin
            logic [LW-1:0] expw = merge_exp(base, dline(idx), off, len);
            chk(mem_wr_valid && mem_addr == laddr, "R8 write issued",
                LW'({mem_wr_valid, mem_addr}), LW'({1'b1, laddr}));
            chk(mem_wr_line == expw, "R8 merged line", mem_wr_line, expw);
            @(negedge clk);
            chk(!dma_out_valid, "R9 no ack before memory ack", LW'(dma_out_valid), LW'(0));
            mem_wr_done = 1'b1;
            @(negedge clk);
            mem_wr_done = 1'b0;
            chk(dma_out_valid && dma_out_ack && dir_state == 2'd2 && dma_out_id == 4'(idx),
                "R9 write ack and Exclusive", LW'({dma_out_valid, dma_out_ack, dir_state}),
                LW'({1'b1, 1'b1, 2'd2}));
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_accept && !snoop_valid && !done_valid && !dma_out_valid && !mem_wr_valid && !stray_resp,
            "R1 reset state", LW'({req_accept, snoop_valid, done_valid, dma_out_valid, mem_wr_valid, stray_resp}),
            LW'(6'b100000));

        for (int i = 0; i < NV; i++) run_vec(i, VEC[i]);

        // R10: stray response while idle
        rsp_valid = 1'b1; rsp_kind = 2'd3; rsp_line = cline(9, 9);
        #1 chk(stray_resp, "R10 stray while idle", LW'(stray_resp), LW'(1));
        @(negedge clk);
        rsp_valid = 1'b0;

        // R2 busy recycle, R10 extra response mid-transaction, R4 count
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0002_0000; req_len = '0;
        req_line_state = 2'd2; req_id = 4'hA;
        @(negedge clk);
        req_id = 4'h5; req_addr = 32'h0003_0000;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(!req_accept && !snoop_valid, "R2 busy request not taken",
                LW'({req_accept, snoop_valid}), LW'(0));
        end
        req_valid = 1'b0;
        for (int k = 0; k < NC; k++) begin
            rsp_valid = 1'b1; rsp_kind = 2'd0;
            #1 chk(!stray_resp, "R4 counted response not stray", LW'(stray_resp), LW'(0));
            @(negedge clk);
        end
        rsp_kind = 2'd1; rsp_line = cline(9, 1);
        #1 chk(stray_resp, "R10 response beyond count", LW'(stray_resp), LW'(1));
        @(negedge clk);
        rsp_valid = 1'b0;
        chk(!done_valid, "R4 waits for memory data", LW'(done_valid), LW'(0));
        send_mem(12);
        wait_trigger("R4 trigger after all");
        chk(!done_shared, "R10 stray shared ack ignored", LW'(done_shared), LW'(0));
        @(negedge clk);
        chk(dma_out_valid && dma_out_id == 4'hA && dma_out_line == mline(12),
            "R2 reply for original request", LW'({dma_out_id, dma_out_line[31:0]}),
            LW'({4'hA, mline(12)[31:0]}));
        @(negedge clk);
        chk(req_accept, "R2 idle again", LW'(req_accept), LW'(1));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule